// File: doc/BRIEF.md
# Polled Console Register Block

This block is a bus slave that gives a processor access to one character source and one character sink through ordinary loads and stores. It claims a fixed 64 KiB window at the top of the 32-bit address space. Inside that window four word registers sit at fixed offsets: a status word and a data word for the receive side, and a status word and a data word for the transmit side. No memory backs any address in the window.

Software polls bit 0 of a status word until it reads 1, then accesses the matching data word. The device side sets each flag: a byte arriving on the receive handshake sets the receive flag, and an idle transmitter that signals it can take a byte sets the transmit flag. The processor's data access clears the flag again. A load from receive data clears the receive flag. A store to transmit data clears the transmit flag and hands the byte to the device over a valid/ready handshake.

Top module: `console_mmio`

## Requirements
- R1: `busHit` is 1 exactly when `busSel` is 1 and `busAddr[31:16]` equals 16'hFFFF. An access outside that window returns `busRdata` = 0 and changes no state.
- R2: Inside the window the word offsets are fixed. Receive status is at 0x0, receive data at 0x4, transmit status at 0x8 and transmit data at 0xC. Any other offset, including an unaligned one, reads 0 and has no effect. `busRdata` is 0 on every write cycle.
- R3: A cycle with `rxValid`=1 captures `rxData`. From the next cycle on, receive status bit 0 reads 1. `rxReady` is always 1, because bytes are never refused.
- R4: A load from receive data returns the held byte in bits 7:0 with bits 31:8 zero. Receive status bit 0 reads 0 from the next cycle on. If a new byte arrives in the same cycle as that load, the flag stays 1 and the new byte is held.
- R5: A byte that arrives while receive status bit 0 is 1 and is not being read in that cycle replaces the held byte. It also sets receive status bit 1. Bit 1 stays 1 until reset.
- R6: A store to transmit data captures `busWdata[7:0]`. From the next cycle `txValid` is 1 and `txData` carries that byte. Both hold steady until a cycle with `txReady`=1, after which `txValid` drops.
- R7: Transmit status bit 0 reads 1 from the cycle after one in which `txReady`=1 and no byte is pending. It reads 0 from the cycle after a store to transmit data.
- R8: Status word bits above the defined flags read 0. Stores to either status word change nothing.
- R9: After reset both ready flags and the overrun flag read 0, and `txValid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Processor access this cycle |
| busWrite | input | 1 | 1 = store, 0 = load |
| busAddr | input | 32 | Byte address |
| busWdata | input | 32 | Store data |
| busRdata | output | 32 | Load data, valid in the access cycle |
| busHit | output | 1 | Address falls in the register window |
| rxValid | input | 1 | Device offers a received byte |
| rxData | input | 8 | Received byte |
| rxReady | output | 1 | Always 1: the byte is taken |
| txValid | output | 1 | A byte awaits the device |
| txData | output | 8 | Byte for the device |
| txReady | input | 1 | Device can take a byte |

## Verification
The hardest case to reach is a receive byte that arrives in the very cycle software reads the previous byte. The R4 priority rule decides whether the flag survives and whether an overrun is wrongly flagged. The bench first parks a byte, then drives `rxValid` together with a receive-data load in one cycle. After that it reads both status and data to show the second byte was kept without setting overrun. The bench also holds `txReady` low across several cycles after a store so it can watch `txData` stay frozen. It then releases `txReady` and follows the one-cycle gap before the transmit flag returns.

// File: rtl/console_pkg.sv
package console_pkg;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_RX_STAT,
    SEL_RX_DATA,
    SEL_TX_STAT,
    SEL_TX_DATA
  } regSel_e;

  typedef struct packed {
    regSel_e regSel;
    logic    rdEn;
    logic    popRx;
    logic    pushTx;
  } strobe_t;

endpackage

// File: rtl/console_ctrl.sv
module console_ctrl
  import console_pkg::*;
#(
  parameter int          ADDR_W   = 32,
  parameter int          WIN_BITS = 16,
  parameter logic [31:0] BASE     = 32'hFFFF0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  output logic              busHit,
  output strobe_t           strb
);
  localparam int TAG_W = ADDR_W - WIN_BITS;
  localparam logic [TAG_W-1:0]    WIN_TAG   = BASE[ADDR_W-1:WIN_BITS];
  localparam logic [WIN_BITS-1:0] OFF_RX_ST = WIN_BITS'(0);
  localparam logic [WIN_BITS-1:0] OFF_RX_DT = WIN_BITS'(4);
  localparam logic [WIN_BITS-1:0] OFF_TX_ST = WIN_BITS'(8);
  localparam logic [WIN_BITS-1:0] OFF_TX_DT = WIN_BITS'(12);

  logic [WIN_BITS-1:0] offset;
  regSel_e             sel;

  always_comb begin
    busHit = busSel && (busAddr[ADDR_W-1:WIN_BITS] == WIN_TAG);
    offset = busAddr[WIN_BITS-1:0];
    sel    = SEL_NONE;
    if (busHit) begin
      case (offset)
        OFF_RX_ST: sel = SEL_RX_STAT;
        OFF_RX_DT: sel = SEL_RX_DATA;
        OFF_TX_ST: sel = SEL_TX_STAT;
        OFF_TX_DT: sel = SEL_TX_DATA;
        default:   sel = SEL_NONE;
      endcase
    end
    strb.regSel = sel;
    strb.rdEn   = busHit && !busWrite;
    strb.popRx  = busHit && !busWrite && (sel == SEL_RX_DATA);
    strb.pushTx = busHit && busWrite && (sel == SEL_TX_DATA);
  end

  // R2
  one_side_effect_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.popRx, strb.pushTx}));

  // R1
  no_strobe_outside_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busHit |-> (!strb.popRx && !strb.pushTx && !strb.rdEn));

endmodule

// File: rtl/console_dp.sv
module console_dp
  import console_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [BYTE_W-1:0] wrByte,
  output logic [DATA_W-1:0] busRdata,
  input  logic              rxValid,
  input  logic [BYTE_W-1:0] rxData,
  output logic              txValid,
  output logic [BYTE_W-1:0] txData,
  input  logic              txReady
);
  logic [BYTE_W-1:0] rxByte;
  logic              rxFull;
  logic              rxOverrun;
  logic [BYTE_W-1:0] txByte;
  logic              txPending;
  logic              txFree;

  // receive side: arrival beats the clearing load
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxByte    <= '0;
      rxFull    <= 1'b0;
      rxOverrun <= 1'b0;
    end else if (rxValid) begin
      rxByte <= rxData;
      rxFull <= 1'b1;
      if (rxFull && !strb.popRx) rxOverrun <= 1'b1;
    end else if (strb.popRx) begin
      rxFull <= 1'b0;
    end
  end

  // transmit side: a store beats the device's set
  always_ff @(posedge clk) begin
    if (!rstN) begin
      txByte    <= '0;
      txPending <= 1'b0;
      txFree    <= 1'b0;
    end else if (strb.pushTx) begin
      txByte    <= wrByte;
      txPending <= 1'b1;
      txFree    <= 1'b0;
    end else begin
      if (txPending && txReady) txPending <= 1'b0;
      if (!txPending && txReady) txFree <= 1'b1;
    end
  end

  always_comb begin
    busRdata = '0;
    if (strb.rdEn) begin
      case (strb.regSel)
        SEL_RX_STAT: begin
          busRdata[0] = rxFull;
          busRdata[1] = rxOverrun;
        end
        SEL_RX_DATA: busRdata[BYTE_W-1:0] = rxByte;
        SEL_TX_STAT: busRdata[0] = txFree;
        default:     busRdata = '0;
      endcase
    end
  end

  assign txValid = txPending;
  assign txData  = txByte;

  // R3
  rx_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> rxFull);

  // R4
  rx_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.popRx && !rxValid) |=> !rxFull);

  // R5
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxOverrun |=> rxOverrun);

  // R6
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && !txReady && !strb.pushTx) |=> (txValid && $stable(txData)));

  // R7
  tx_flag_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.pushTx |=> (!txFree && txValid));

endmodule

// File: rtl/console_mmio.sv
module console_mmio
  import console_pkg::*;
#(
  parameter int          ADDR_W   = 32,
  parameter int          DATA_W   = 32,
  parameter int          BYTE_W   = 8,
  parameter int          WIN_BITS = 16,
  parameter logic [31:0] BASE     = 32'hFFFF0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              busHit,
  input  logic              rxValid,
  input  logic [BYTE_W-1:0] rxData,
  output logic              rxReady,
  output logic              txValid,
  output logic [BYTE_W-1:0] txData,
  input  logic              txReady
);
  strobe_t strb;
  logic    wdataUnused;

  assign wdataUnused = ^busWdata[DATA_W-1:BYTE_W];
  assign rxReady     = 1'b1;

  console_ctrl #(
    .ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS), .BASE(BASE)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busHit(busHit), .strb(strb)
  );

  console_dp #(
    .DATA_W(DATA_W), .BYTE_W(BYTE_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrByte(busWdata[BYTE_W-1:0]),
    .busRdata(busRdata), .rxValid(rxValid), .rxData(rxData),
    .txValid(txValid), .txData(txData), .txReady(txReady)
  );

  // R8
  stat_upper_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busHit && !busWrite && (busAddr[3:0] == 4'h8)) |-> (busRdata[DATA_W-1:1] == '0));

endmodule

// File: tb/console_mmio_tb.sv
module console_mmio_tb;
  logic        clk = 1'b0;
  logic        rstN;
  logic        busSel, busWrite;
  logic [31:0] busAddr, busWdata, busRdata;
  logic        busHit;
  logic        rxValid;
  logic [7:0]  rxData;
  logic        rxReady, txValid;
  logic [7:0]  txData;
  logic        txReady;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  console_mmio u_dut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .busHit(busHit), .rxValid(rxValid), .rxData(rxData), .rxReady(rxReady),
    .txValid(txValid), .txData(txData), .txReady(txReady)
  );

  typedef struct packed {
    logic        sel;
    logic        wr;
    logic [31:0] addr;
    logic [31:0] wdata;
    logic        rxv;
    logic [7:0]  rxd;
    logic        txr;
    logic [31:0] expRd;
    logic        expHit;
    logic        expTxv;
    logic [7:0]  expTxd;
  } vec_t;

  localparam int NV = 25;
  localparam vec_t VEC [NV] = '{
    '{1'b1,1'b0,32'hFFFF0000,32'h0,1'b0,8'h00,1'b0,32'h0,1'b1,1'b0,8'h00}, // 0 R9
    '{1'b1,1'b0,32'hFFFF0000,32'h0,1'b1,8'h41,1'b0,32'h0,1'b1,1'b0,8'h00}, // 1 R3
    '{1'b1,1'b0,32'hFFFF0000,32'h0,1'b0,8'h00,1'b0,32'h1,1'b1,1'b0,8'h00}, // 2 R3
    '{1'b1,1'b0,32'hFFFF0004,32'h0,1'b0,8'h00,1'b0,32'h41,1'b1,1'b0,8'h00}, // 3 R4
    '{1'b1,1'b0,32'hFFFF0000,32'h0,1'b0,8'h00,1'b0,32'h0,1'b1,1'b0,8'h00}, // 4 R4
    '{1'b0,1'b0,32'hFFFF0000,32'h0,1'b1,8'h42,1'b0,32'h0,1'b0,1'b0,8'h00}, // 5 R3
    '{1'b0,1'b0,32'hFFFF0000,32'h0,1'b1,8'hC3,1'b0,32'h0,1'b0,1'b0,8'h00}, // 6 R5
    '{1'b1,1'b0,32'hFFFF0000,32'h0,1'b0,8'h00,1'b0,32'h3,1'b1,1'b0,8'h00}, // 7 R5
    '{1'b1,1'b0,32'hFFFF0004,32'h0,1'b0,8'h00,1'b0,32'hC3,1'b1,1'b0,8'h00}, // 8 R5 R4
    '{1'b1,1'b0,32'hFFFF0000,32'h0,1'b0,8'h00,1'b0,32'h2,1'b1,1'b0,8'h00}, // 9 R5
    '{1'b1,1'b1,32'hFFFF0000,32'hFFFFFFFF,1'b0,8'h00,1'b0,32'h0,1'b1,1'b0,8'h00}, // 10 R8
    '{1'b1,1'b0,32'hFFFF0000,32'h0,1'b0,8'h00,1'b0,32'h2,1'b1,1'b0,8'h00}, // 11 R8
    '{1'b1,1'b0,32'hFFFF0008,32'h0,1'b0,8'h00,1'b0,32'h0,1'b1,1'b0,8'h00}, // 12 R7
    '{1'b0,1'b0,32'h0,32'h0,1'b0,8'h00,1'b1,32'h0,1'b0,1'b0,8'h00}, // 13 R7
    '{1'b1,1'b0,32'hFFFF0008,32'h0,1'b0,8'h00,1'b1,32'h1,1'b1,1'b0,8'h00}, // 14 R7
    '{1'b1,1'b1,32'hFFFF000C,32'h12345655,1'b0,8'h00,1'b0,32'h0,1'b1,1'b0,8'h00}, // 15 R6
    '{1'b1,1'b0,32'hFFFF0008,32'h0,1'b0,8'h00,1'b0,32'h0,1'b1,1'b1,8'h55}, // 16 R6 R7
    '{1'b1,1'b0,32'hFFFF000C,32'h0,1'b0,8'h00,1'b1,32'h0,1'b1,1'b1,8'h55}, // 17 R6
    '{1'b1,1'b0,32'hFFFF0008,32'h0,1'b0,8'h00,1'b1,32'h0,1'b1,1'b0,8'h00}, // 18 R7
    '{1'b1,1'b0,32'hFFFF0008,32'h0,1'b0,8'h00,1'b0,32'h1,1'b1,1'b0,8'h00}, // 19 R7
    '{1'b1,1'b0,32'hFFFF0010,32'h0,1'b0,8'h00,1'b0,32'h0,1'b1,1'b0,8'h00}, // 20 R2
    '{1'b1,1'b0,32'hFFFF0002,32'h0,1'b0,8'h00,1'b0,32'h0,1'b1,1'b0,8'h00}, // 21 R2
    '{1'b1,1'b0,32'h00000000,32'h0,1'b0,8'h00,1'b0,32'h0,1'b0,1'b0,8'h00}, // 22 R1
    '{1'b1,1'b1,32'hFFFE000C,32'h77,1'b0,8'h00,1'b0,32'h0,1'b0,1'b0,8'h00}, // 23 R1
    '{1'b1,1'b0,32'hFFFF0008,32'h0,1'b0,8'h00,1'b0,32'h1,1'b1,1'b0,8'h00}  // 24 R1 R7
  };

  task automatic drive(input logic s, input logic w, input logic [31:0] a,
                       input logic [31:0] d, input logic rv, input logic [7:0] rd,
                       input logic tr);
    @(negedge clk);
    busSel = s; busWrite = w; busAddr = a; busWdata = d;
    rxValid = rv; rxData = rd; txReady = tr;
    #5;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    busSel = 0; busWrite = 0; busAddr = 0; busWdata = 0;
    rxValid = 0; rxData = 0; txReady = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin
    #1000000;
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    doReset();
    // R9 reset state
    #5;
    chk("R9 txValid", {31'b0, txValid}, 32'h0);
    chk("R3 rxReady", {31'b0, rxReady}, 32'h1);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i].sel, VEC[i].wr, VEC[i].addr, VEC[i].wdata,
            VEC[i].rxv, VEC[i].rxd, VEC[i].txr);
      chk($sformatf("vec%0d rdata R1/R2", i), busRdata, VEC[i].expRd);
      chk($sformatf("vec%0d hit R1", i), {31'b0, busHit}, {31'b0, VEC[i].expHit});
      chk($sformatf("vec%0d txValid R6", i), {31'b0, txValid}, {31'b0, VEC[i].expTxv});
      if (VEC[i].expTxv) chk($sformatf("vec%0d txData R6", i), {24'b0, txData}, {24'b0, VEC[i].expTxd});
    end

    // R9: reset mid-activity clears overrun and flags
    drive(1, 1, 32'hFFFF000C, 32'hEE, 1, 8'h99, 0);
    doReset();
    drive(1, 0, 32'hFFFF0000, 0, 0, 0, 0);
    chk("R9 rx status after reset", busRdata, 32'h0);
    chk("R9 txValid after reset", {31'b0, txValid}, 32'h0);
    drive(1, 0, 32'hFFFF0008, 0, 0, 0, 0);
    chk("R9 tx status after reset", busRdata, 32'h0);

    // R4: arrival in the same cycle as the clearing load
    drive(0, 0, 0, 0, 1, 8'h10, 0);
    drive(1, 0, 32'hFFFF0004, 0, 1, 8'h11, 0);
    chk("R4 old byte read", busRdata, 32'h10);
    drive(1, 0, 32'hFFFF0000, 0, 0, 0, 0);
    chk("R4 R5 flag kept, no overrun", busRdata, 32'h1);
    drive(1, 0, 32'hFFFF0004, 0, 0, 0, 0);
    chk("R4 new byte held", busRdata, 32'h11);

    // R8: store to tx status while clear is ignored
    drive(1, 1, 32'hFFFF0008, 32'h1, 0, 0, 0);
    drive(1, 0, 32'hFFFF0008, 0, 0, 0, 0);
    chk("R8 tx status store ignored", busRdata, 32'h0);

    // R6: byte held across a stall
    drive(1, 1, 32'hFFFF000C, 32'hFFFFFFA5, 0, 0, 0);
    for (int k = 0; k < 3; k++) begin
      drive(0, 0, 0, 0, 0, 0, 0);
      chk("R6 stall txValid", {31'b0, txValid}, 32'h1);
      chk("R6 stall txData", {24'b0, txData}, 32'hA5);
    end
    drive(0, 0, 0, 0, 0, 0, 1);
    drive(0, 0, 0, 0, 0, 0, 0);
    chk("R6 txValid drops", {31'b0, txValid}, 32'h0);

    summary();
  end
endmodule